// File: doc/BRIEF.md
# EEPROM Image Cache with Checksum Validation

This block keeps a local copy of a 64-word, 16-bit configuration EEPROM and decides whether that copy can be trusted. It sits above a word-level memory port that takes one read or write at a time. It offers a single command interface with four operations. **Lookup** returns a word from the copy. **Load** rereads the whole image. **Write** stores one word in the EEPROM. **Checksum fix** recomputes and writes back the last word of the image.

An image is trusted only when two conditions hold. First, all 64 words must add up to 16'hBABA modulo 2^16. Second, the init-control word at index 10 must match a masked signature: its two top bits must read `01`. When the sum is wrong, the cached init-control word is cleared. When the signature is wrong, the load also fails. In either case the status output shows which check failed.

Loading is lazy. A lookup whose cached signature is intact is answered straight from the copy. A lookup whose cached signature is broken first triggers a full reload. Every write and every checksum fix clears the cached init-control word, so the next lookup reloads. A 32-bit assembly number, built from words 9 (high) and 8 (low), is presented while the copy is trusted.

Top module: `eeprom_image_cache`

## Requirements
- R1: A reload reads addresses 0 to 63 in ascending order, one request at a time. `memReq` stays high, with address and data steady, until a one-cycle `memDone` pulse. A request still high in the cycle after `memDone` is a new request. `cmdReady` is low while any request is pending.
- R2: After a reload, if the 16-bit wrapping sum of the 64 words is not 16'hBABA, status becomes 3 (checksum error). The cached word 10 is also cleared to 16'h0000, so the lookup answers 0 and every later lookup reloads again.
- R3: With a good sum, status becomes 2 (valid) when (word10 & 16'hC000) == 16'h4000, and 4 (signature error) otherwise. A lookup answers 0 after a signature error.
- R4: While the cached word 10 carries the valid signature, a lookup is answered from the copy with `cmdDone` high in the cycle after acceptance. It makes no downstream request and does not see EEPROM changes made since the last load.
- R5: A lookup that finds the cached signature broken performs a full reload first, then answers with the requested word.
- R6: A lookup with index 64 or more answers 0 one cycle after acceptance, with no downstream access, whether or not the copy is valid.
- R7: Write (op 2) issues exactly one downstream write of `cmdWData` at `cmdIdx[5:0]` and answers 0. It then clears the cached word 10, sets status to 0, and the next lookup reloads.
- R8: Checksum fix (op 3) reads words 0 to 62. It writes 16'hBABA minus their wrapping sum to word 63, and answers with that value. Like a write, it clears the cached word 10 and sets status to 0.
- R9: `asmNumber` equals {word9, word8} of the copy while the cached signature is valid, and 0 otherwise.
- R10: Status reads 0 (idle) after reset and 1 (loading) during a reload. Load (op 1) always rereads the image and answers 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command request, taken when `cmdReady` is high |
| cmdOp | input | 2 | 0 lookup, 1 load, 2 write, 3 checksum fix |
| cmdIdx | input | 7 | Word index for lookup and write |
| cmdWData | input | 16 | Data for write |
| cmdReady | output | 1 | High when idle and able to take a command |
| cmdDone | output | 1 | One-cycle completion pulse |
| cmdRspData | output | 16 | Answer, valid while `cmdDone` is high |
| status | output | 3 | 0 idle, 1 loading, 2 valid, 3 checksum error, 4 signature error |
| asmNumber | output | 32 | {word9, word8} when valid, else 0 |
| memReq | output | 1 | Downstream request, held until `memDone` |
| memWrite | output | 1 | Downstream direction, 1 for write |
| memAddr | output | 6 | Downstream word address |
| memWData | output | 16 | Downstream write data |
| memDone | input | 1 | Downstream completion pulse |
| memRData | input | 16 | Downstream read data, valid with `memDone` |

## Verification
A wrong running sum or a dropped word stays hidden during the reload. It shows up at the end of the reload, in the status code and in whether the lookup answers the stored word or 0. A copy that is wrongly left trusted after a write shows up on the very next lookup: that lookup answers in one cycle with no downstream reads, instead of reloading 64 words. A copy that is wrongly distrusted shows up as 64 unexpected reads on a lookup that should have taken one cycle, and as `asmNumber` dropping to zero.

// File: rtl/eic_pkg.sv
package eic_pkg;

  typedef enum logic [2:0] {
    STAT_IDLE     = 3'd0,
    STAT_LOADING  = 3'd1,
    STAT_VALID    = 3'd2,
    STAT_CSUM_ERR = 3'd3,
    STAT_SIG_ERR  = 3'd4
  } statCode_t;

  typedef enum logic [1:0] {
    OP_LOOKUP = 2'd0,
    OP_LOAD   = 2'd1,
    OP_WRITE  = 2'd2,
    OP_FIXSUM = 2'd3
  } cmdOp_t;

  typedef enum logic [1:0] {
    ADDR_CNT  = 2'd0,
    ADDR_IDX  = 2'd1,
    ADDR_CSUM = 2'd2
  } addrSel_t;

  typedef enum logic [1:0] {
    RSP_ZERO = 2'd0,
    RSP_WORD = 2'd1,
    RSP_FIX  = 2'd2
  } rspSel_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic     latchCmd;
    logic     clrRun;
    logic     accRead;
    logic     storeWord;
    logic     clearInit;
    addrSel_t addrSel;
    logic     wdFix;
    rspSel_t  rspSel;
  } dpStrobe_t;

endpackage

// File: rtl/eic_datapath.sv
module eic_datapath
  import eic_pkg::*;
#(
  parameter int WORDS = 64,
  parameter int DW = 16,
  parameter int INIT_IDX = 10,
  parameter int ASM_LO = 8,
  parameter int ASM_HI = 9,
  parameter logic [15:0] SUM_TARGET = 16'hBABA,
  parameter logic [15:0] SIG_MASK = 16'hC000,
  parameter logic [15:0] SIG_VALUE = 16'h4000,
  parameter logic [15:0] SIG_CLEAR = 16'h0000,
  localparam int AW = $clog2(WORDS),
  localparam int IW = AW + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpStrobe_t       strb,
  input  logic [IW-1:0]   cmdIdx,
  input  logic [DW-1:0]   cmdWData,
  input  logic [DW-1:0]   memRData,
  output logic [AW-1:0]   memAddr,
  output logic [DW-1:0]   memWData,
  output logic [DW-1:0]   rspData,
  output logic [2*DW-1:0] asmNumber,
  output logic            sigOk,
  output logic            sumOk,
  output logic            cntLoadEnd,
  output logic            cntFixEnd
);

  localparam logic [AW-1:0] LAST_ADDR = AW'(WORDS - 1);
  localparam logic [AW-1:0] FIX_LAST = AW'(WORDS - 2);
  localparam logic [IW-1:0] IDX_LIMIT = IW'(WORDS);

  logic [DW-1:0] cache [WORDS];
  logic [DW-1:0] acc;
  logic [AW-1:0] cnt;
  logic [IW-1:0] idxReg;
  logic [DW-1:0] wdReg;
  logic [DW-1:0] fixVal;
  logic          idxBig;

  // image copy: filled word by word during a reload, init word cleared on demand
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < WORDS; w++) cache[w] <= '0;
    end else begin
      if (strb.storeWord) cache[cnt] <= memRData;
      if (strb.clearInit) cache[INIT_IDX] <= DW'(SIG_CLEAR);
    end
  end

  // running sum and word counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc <= '0;
      cnt <= '0;
    end else if (strb.clrRun) begin
      acc <= '0;
      cnt <= '0;
    end else if (strb.accRead) begin
      acc <= acc + memRData;
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxReg <= '0;
      wdReg  <= '0;
    end else if (strb.latchCmd) begin
      idxReg <= cmdIdx;
      wdReg  <= cmdWData;
    end
  end

  assign idxBig     = idxReg >= IDX_LIMIT;
  assign sigOk      = (cache[INIT_IDX] & DW'(SIG_MASK)) == DW'(SIG_VALUE);
  assign sumOk      = acc == DW'(SUM_TARGET);
  assign fixVal     = DW'(SUM_TARGET) - acc;
  assign cntLoadEnd = cnt == LAST_ADDR;
  assign cntFixEnd  = cnt == FIX_LAST;
  assign asmNumber  = sigOk ? {cache[ASM_HI], cache[ASM_LO]} : '0;
  assign memWData   = strb.wdFix ? fixVal : wdReg;

  always_comb begin
    unique case (strb.addrSel)
      ADDR_IDX:  memAddr = idxReg[AW-1:0];
      ADDR_CSUM: memAddr = LAST_ADDR;
      default:   memAddr = cnt;
    endcase
  end

  always_comb begin
    unique case (strb.rspSel)
      RSP_WORD: rspData = (sigOk && !idxBig) ? cache[idxReg[AW-1:0]] : '0;
      RSP_FIX:  rspData = fixVal;
      default:  rspData = '0;
    endcase
  end

  // R7
  inval_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearInit |=> !sigOk);

endmodule

// File: rtl/eic_ctrl.sv
module eic_ctrl
  import eic_pkg::*;
#(
  parameter int WORDS = 64,
  localparam int AW = $clog2(WORDS),
  localparam int IW = AW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  input  logic [1:0]    cmdOp,
  input  logic [IW-1:0] cmdIdx,
  input  logic          memDone,
  input  logic          sigOk,
  input  logic          sumOk,
  input  logic          cntLoadEnd,
  input  logic          cntFixEnd,
  output logic          cmdReady,
  output logic          cmdDone,
  output logic          memReq,
  output logic          memWrite,
  output logic [2:0]    status,
  output dpStrobe_t     strb
);

  localparam logic [IW-1:0] IDX_LIMIT = IW'(WORDS);

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_EVAL, S_FIXRD, S_FIXWR, S_WRITE, S_RESP
  } state_t;

  state_t    state, stateNext;
  statCode_t statReg, statNext;
  cmdOp_t    opReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      statReg <= STAT_IDLE;
      opReg   <= OP_LOOKUP;
    end else begin
      state   <= stateNext;
      statReg <= statNext;
      if (strb.latchCmd) opReg <= cmdOp_t'(cmdOp);
    end
  end

  always_comb begin
    stateNext = state;
    statNext  = statReg;
    strb      = '0;
    strb.addrSel = ADDR_CNT;
    strb.rspSel  = RSP_ZERO;
    cmdReady  = 1'b0;
    cmdDone   = 1'b0;
    memReq    = 1'b0;
    memWrite  = 1'b0;
    unique case (state)
      S_IDLE: begin
        cmdReady = 1'b1;
        if (cmdValid) begin
          strb.latchCmd = 1'b1;
          strb.clrRun   = 1'b1;
          unique case (cmdOp_t'(cmdOp))
            OP_LOOKUP: stateNext = (cmdIdx >= IDX_LIMIT || sigOk) ? S_RESP : S_LOAD;
            OP_LOAD:   stateNext = S_LOAD;
            OP_WRITE:  stateNext = S_WRITE;
            default:   stateNext = S_FIXRD;
          endcase
        end
      end
      S_LOAD: begin
        memReq = 1'b1;
        if (memDone) begin
          strb.storeWord = 1'b1;
          strb.accRead   = 1'b1;
          if (cntLoadEnd) stateNext = S_EVAL;
        end
      end
      S_EVAL: begin
        if (!sumOk) begin
          strb.clearInit = 1'b1;
          statNext = STAT_CSUM_ERR;
        end else if (!sigOk) begin
          statNext = STAT_SIG_ERR;
        end else begin
          statNext = STAT_VALID;
        end
        stateNext = S_RESP;
      end
      S_FIXRD: begin
        memReq = 1'b1;
        if (memDone) begin
          strb.accRead = 1'b1;
          if (cntFixEnd) stateNext = S_FIXWR;
        end
      end
      S_FIXWR: begin
        memReq       = 1'b1;
        memWrite     = 1'b1;
        strb.addrSel = ADDR_CSUM;
        strb.wdFix   = 1'b1;
        if (memDone) begin
          strb.clearInit = 1'b1;
          statNext  = STAT_IDLE;
          stateNext = S_RESP;
        end
      end
      S_WRITE: begin
        memReq       = 1'b1;
        memWrite     = 1'b1;
        strb.addrSel = ADDR_IDX;
        if (memDone) begin
          strb.clearInit = 1'b1;
          statNext  = STAT_IDLE;
          stateNext = S_RESP;
        end
      end
      S_RESP: begin
        cmdDone = 1'b1;
        unique case (opReg)
          OP_LOOKUP: strb.rspSel = RSP_WORD;
          OP_FIXSUM: strb.rspSel = RSP_FIX;
          default:   strb.rspSel = RSP_ZERO;
        endcase
        stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  assign status = (state == S_LOAD || state == S_EVAL) ? 3'(STAT_LOADING) : 3'(statReg);

  // R1
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memDone |=> memReq);

  // R1
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !cmdReady);

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdDone |=> !cmdDone);

  // R3
  valid_sig_chk: assert property (@(posedge clk) disable iff (!rstN)
    status == 3'(STAT_VALID) |-> sigOk);

endmodule

// File: rtl/eeprom_image_cache.sv
module eeprom_image_cache
  import eic_pkg::*;
#(
  parameter int WORDS = 64,
  parameter int DW = 16,
  parameter int INIT_IDX = 10,
  parameter int ASM_LO = 8,
  parameter int ASM_HI = 9,
  parameter logic [15:0] SUM_TARGET = 16'hBABA,
  parameter logic [15:0] SIG_MASK = 16'hC000,
  parameter logic [15:0] SIG_VALUE = 16'h4000,
  parameter logic [15:0] SIG_CLEAR = 16'h0000,
  localparam int AW = $clog2(WORDS),
  localparam int IW = AW + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  input  logic [1:0]      cmdOp,
  input  logic [IW-1:0]   cmdIdx,
  input  logic [DW-1:0]   cmdWData,
  output logic            cmdReady,
  output logic            cmdDone,
  output logic [DW-1:0]   cmdRspData,
  output logic [2:0]      status,
  output logic [2*DW-1:0] asmNumber,
  output logic            memReq,
  output logic            memWrite,
  output logic [AW-1:0]   memAddr,
  output logic [DW-1:0]   memWData,
  input  logic            memDone,
  input  logic [DW-1:0]   memRData
);

  dpStrobe_t strb;
  logic sigOk, sumOk, cntLoadEnd, cntFixEnd;

  eic_ctrl #(.WORDS(WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdIdx(cmdIdx),
    .memDone(memDone), .sigOk(sigOk), .sumOk(sumOk), .cntLoadEnd(cntLoadEnd),
    .cntFixEnd(cntFixEnd), .cmdReady(cmdReady), .cmdDone(cmdDone), .memReq(memReq),
    .memWrite(memWrite), .status(status), .strb(strb)
  );

  eic_datapath #(
    .WORDS(WORDS), .DW(DW), .INIT_IDX(INIT_IDX), .ASM_LO(ASM_LO), .ASM_HI(ASM_HI),
    .SUM_TARGET(SUM_TARGET), .SIG_MASK(SIG_MASK), .SIG_VALUE(SIG_VALUE),
    .SIG_CLEAR(SIG_CLEAR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdIdx(cmdIdx), .cmdWData(cmdWData),
    .memRData(memRData), .memAddr(memAddr), .memWData(memWData), .rspData(cmdRspData),
    .asmNumber(asmNumber), .sigOk(sigOk), .sumOk(sumOk), .cntLoadEnd(cntLoadEnd),
    .cntFixEnd(cntFixEnd)
  );

  // R1
  req_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memDone |=> $stable(memAddr) && $stable(memWrite) && $stable(memWData));

  // R7
  wr_inval_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWrite && memDone |=> !sigOk);

endmodule

// File: tb/eeprom_image_cache_tb.sv
module eeprom_image_cache_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdOp = 2'd0;
  logic [6:0]  cmdIdx = 7'd0;
  logic [15:0] cmdWData = 16'd0;
  logic        cmdReady, cmdDone;
  logic [15:0] cmdRspData;
  logic [2:0]  status;
  logic [31:0] asmNumber;
  logic        memReq, memWrite;
  logic [5:0]  memAddr;
  logic [15:0] memWData;
  logic        memDone;
  logic [15:0] memRData;

  always #10 clk = ~clk;

  eeprom_image_cache u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdIdx(cmdIdx),
    .cmdWData(cmdWData), .cmdReady(cmdReady), .cmdDone(cmdDone), .cmdRspData(cmdRspData),
    .status(status), .asmNumber(asmNumber), .memReq(memReq), .memWrite(memWrite),
    .memAddr(memAddr), .memWData(memWData), .memDone(memDone), .memRData(memRData)
  );

  // EEPROM model: latency 1..3 cycles by address, contents mirrored by the bench
  logic [15:0] mem [64];
  logic        busy;
  int          waitCnt, rdCount, wrCount, seqBad, lastRd;
  logic [5:0]  curA, lastWrA;
  logic        curW;
  logic [15:0] lastWrD;

  always @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0; memDone <= 1'b0; memRData <= 16'd0; waitCnt <= 0;
      rdCount <= 0; wrCount <= 0; seqBad <= 0; lastRd <= 63;
      curA <= 6'd0; curW <= 1'b0; lastWrA <= 6'd0; lastWrD <= 16'd0;
    end else begin
      memDone <= 1'b0;
      if (busy) begin
        if (waitCnt == 0) begin
          busy <= 1'b0;
          memDone <= 1'b1;
          if (!curW) memRData <= mem[curA];
        end else waitCnt <= waitCnt - 1;
      end else if (memReq && !memDone) begin
        busy <= 1'b1;
        waitCnt <= int'(memAddr) % 3;
        curA <= memAddr;
        curW <= memWrite;
        if (memWrite) begin
          wrCount <= wrCount + 1; lastWrA <= memAddr; lastWrD <= memWData;
        end else begin
          rdCount <= rdCount + 1;
          if (!(memAddr == 6'd0 || int'(memAddr) == lastRd + 1)) seqBad <= seqBad + 1;
          lastRd <= int'(memAddr);
        end
      end
    end
  end

  int total = 0;
  int bad = 0;
  logic finished = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] sum62();
    logic [15:0] s = 16'd0;
    for (int i = 0; i < 63; i++) s = s + mem[i];
    return s;
  endfunction

  logic [15:0] rsp;
  int          cyc;
  logic [2:0]  midStat;

  task automatic doCmd(input logic [1:0] op, input logic [6:0] idx, input logic [15:0] wd);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdIdx = idx; cmdWData = wd;
    @(negedge clk);
    cmdValid = 1'b0;
    cyc = 1;
    midStat = status;
    while (!cmdDone && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    rsp = cmdRspData;
    if (!cmdDone) chk("R1 command completion", 32'd0, 32'd1);
  endtask

  task automatic sealImage();
    mem[63] = 16'hBABA - sum62();
  endtask

  int r0, w0;
  logic [15:0] expFix, oldWord;

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'(i * 16'h0123 + 16'h0055);
    mem[10] = 16'h4ABC;
    sealImage();
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 reset status", 32'(status), 32'd0);
    chk("R10 reset ready", 32'(cmdReady), 32'd1);
    chk("R1 reset no request", 32'(memReq), 32'd0);
    chk("R9 reset assembly number", asmNumber, 32'd0);

    // first lookup reloads lazily
    r0 = rdCount;
    doCmd(2'd0, 7'd5, 16'd0);
    chk("R5 lookup after reload", 32'(rsp), 32'(mem[5]));
    chk("R1 reload read count", 32'(rdCount - r0), 32'd64);
    chk("R1 reload address order", 32'(seqBad), 32'd0);
    chk("R3 status valid", 32'(status), 32'd2);
    chk("R10 loading status", 32'(midStat), 32'd1);
    chk("R9 assembly number", asmNumber, {mem[9], mem[8]});

    // sweep of every cached word
    r0 = rdCount;
    for (int i = 0; i < 64; i++) begin
      doCmd(2'd0, 7'(i), 16'd0);
      chk("R4 cached lookup data", 32'(rsp), 32'(mem[i]));
      chk("R4 cached lookup latency", 32'(cyc), 32'd1);
    end
    chk("R4 no downstream reads", 32'(rdCount - r0), 32'd0);

    for (int i = 64; i < 128; i += 21) begin
      doCmd(2'd0, 7'(i), 16'd0);
      chk("R6 out of range answer", 32'(rsp), 32'd0);
      chk("R6 out of range latency", 32'(cyc), 32'd1);
    end

    // write breaks the checksum and invalidates
    w0 = wrCount;
    doCmd(2'd2, 7'd20, 16'h1234);
    mem[20] = 16'h1234;
    chk("R7 one write", 32'(wrCount - w0), 32'd1);
    chk("R7 write address", 32'(lastWrA), 32'd20);
    chk("R7 write data", 32'(lastWrD), 32'h1234);
    chk("R7 write answer", 32'(rsp), 32'd0);
    chk("R7 status idle", 32'(status), 32'd0);
    chk("R7 assembly number cleared", asmNumber, 32'd0);

    r0 = rdCount;
    doCmd(2'd0, 7'd100, 16'd0);
    chk("R6 no reload for big index", 32'(rdCount - r0), 32'd0);
    chk("R6 big index answer", 32'(rsp), 32'd0);

    r0 = rdCount;
    doCmd(2'd0, 7'd3, 16'd0);
    chk("R7 reload after write", 32'(rdCount - r0), 32'd64);
    chk("R2 bad sum answer", 32'(rsp), 32'd0);
    chk("R2 checksum error status", 32'(status), 32'd3);
    chk("R2 init cleared", asmNumber, 32'd0);
    r0 = rdCount;
    doCmd(2'd0, 7'd3, 16'd0);
    chk("R2 reload repeats", 32'(rdCount - r0), 32'd64);

    // checksum fix
    expFix = 16'hBABA - sum62();
    r0 = rdCount; w0 = wrCount;
    doCmd(2'd3, 7'd0, 16'd0);
    chk("R8 fix answer", 32'(rsp), 32'(expFix));
    chk("R8 fix write address", 32'(lastWrA), 32'd63);
    chk("R8 fix write data", 32'(lastWrD), 32'(expFix));
    chk("R8 fix read count", 32'(rdCount - r0), 32'd63);
    chk("R8 fix write count", 32'(wrCount - w0), 32'd1);
    chk("R8 fix read order", 32'(seqBad), 32'd0);
    chk("R8 fix status", 32'(status), 32'd0);
    mem[63] = expFix;
    doCmd(2'd0, 7'd20, 16'd0);
    chk("R8 image valid after fix", 32'(rsp), 32'h1234);
    chk("R8 status valid after fix", 32'(status), 32'd2);

    // signature boundaries
    begin
      logic [15:0] sigs [5];
      logic [2:0]  expSt [5];
      sigs[0] = 16'h8ABC; expSt[0] = 3'd4;
      sigs[1] = 16'hC000; expSt[1] = 3'd4;
      sigs[2] = 16'h0000; expSt[2] = 3'd4;
      sigs[3] = 16'h7FFF; expSt[3] = 3'd2;
      sigs[4] = 16'h4000; expSt[4] = 3'd2;
      for (int k = 0; k < 5; k++) begin
        doCmd(2'd2, 7'd10, sigs[k]);
        mem[10] = sigs[k];
        doCmd(2'd3, 7'd0, 16'd0);
        mem[63] = 16'hBABA - sum62();
        doCmd(2'd1, 7'd0, 16'd0);
        chk("R10 load answer", 32'(rsp), 32'd0);
        chk("R3 signature status", 32'(status), 32'(expSt[k]));
        r0 = rdCount;
        doCmd(2'd0, 7'd8, 16'd0);
        chk("R3 lookup after signature check", 32'(rsp),
            expSt[k] == 3'd2 ? 32'(mem[8]) : 32'd0);
        chk("R3 reload on bad signature", 32'(rdCount - r0),
            expSt[k] == 3'd2 ? 32'd0 : 32'd64);
      end
    end

    // contents changed behind the copy: stale until an explicit load
    oldWord = mem[8];
    for (int i = 0; i < 63; i++) mem[i] = ~16'(i * 16'h0311);
    mem[10] = 16'h5555;
    sealImage();
    doCmd(2'd0, 7'd8, 16'd0);
    chk("R4 served from copy", 32'(rsp), 32'(oldWord));
    r0 = rdCount;
    doCmd(2'd1, 7'd0, 16'd0);
    chk("R10 explicit load reads", 32'(rdCount - r0), 32'd64);
    chk("R3 second image valid", 32'(status), 32'd2);
    chk("R9 second image assembly", asmNumber, {mem[9], mem[8]});
    for (int i = 0; i < 64; i++) begin
      doCmd(2'd0, 7'(i), 16'd0);
      chk("R4 second image data", 32'(rsp), 32'(mem[i]));
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=hung expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule